// File: doc/BRIEF.md
# Segment Limit and Address Checker

This block turns a segment-relative memory access into a linear address and decides, in the same step, whether the access is legal under the segment's cached descriptor. A requester names one of several segment registers, gives a 32-bit offset, an access width of one, two or four bytes, and an access kind (read, write or instruction fetch). One cycle later the block returns the linear address, which is the cached base plus the offset modulo 2^32, together with three fault flags. One flag reports a limit breach, one a type breach, and one a descriptor that is marked not present.

Each segment register owns a hidden descriptor cache. A load strobe captures a 64-bit descriptor into the selected entry and decodes its base, its scaled limit and its attributes once, at load time. Translation always uses the captured copy. Changing the descriptor bus without a load therefore has no effect, and a fresh load becomes visible only from the next request cycle. The limit test covers every byte of a multi-byte access, honours 4 KB granularity, and inverts the valid window for expand-down data segments.

Top module: `seg_check_top`

## Requirements
- R1: `rsp_lin_addr` equals the cached base plus `req_offset`, modulo 2^32. The base is taken from descriptor bits 63:56 (upper byte) and 39:16 (lower 24 bits).
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high. The address and fault outputs keep their last values while no request arrives.
- R3: The raw limit is descriptor bits 51:48 over bits 15:0. `req_size` 0, 1 and 2 mean 1, 2 and 4 bytes, and 3 also means 4 bytes. For a segment that is not expand-down, `rsp_limit_fault` is set when offset plus size minus one, computed without wrap, exceeds the effective limit.
- R4: With descriptor bit 55 set, the effective limit is the raw limit times 4096 plus 4095. With bit 55 clear, the effective limit is the raw limit.
- R5: A data segment whose type bits 43:41 are 01x is expand-down. It faults on its limit unless the offset is greater than the effective limit and the last byte is no greater than 0xFFFF (bit 54 clear) or 0xFFFFFFFF (bit 54 set).
- R6: `req_kind` 0 is read, 1 is write, and 2 or 3 is execute. A type fault is raised for a write to any code segment (bit 43 set), a write to data with bit 41 clear, a read from code with bit 41 clear, and an execute from data (bit 43 clear). Conforming code obeys the same rules.
- R7: A descriptor with bit 44 clear (system descriptor) raises `rsp_type_fault` for every access kind.
- R8: A descriptor with bit 47 clear raises `rsp_np_fault`, and both `rsp_limit_fault` and `rsp_type_fault` stay low.
- R9: A descriptor is captured only when `load_valid` selects that segment register. A request in the same cycle as a load still uses the old copy. Other entries are unaffected.
- R10: After reset, `rsp_valid`, the address and all flags are zero, and every cache entry is not present, so a request before any load yields `rsp_np_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_valid | input | 1 | Capture `load_desc` into the selected cache entry |
| load_seg | input | SEL_W | Segment register index for the load |
| load_desc | input | 64 | Descriptor to capture |
| req_valid | input | 1 | Access request strobe |
| req_seg | input | SEL_W | Segment register index for the access |
| req_offset | input | 32 | Offset within the segment |
| req_size | input | 2 | Width code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_kind | input | 2 | 0 read, 1 write, 2 or 3 execute |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_lin_addr | output | 32 | Cached base plus offset |
| rsp_limit_fault | output | 1 | Some byte lies outside the valid window |
| rsp_type_fault | output | 1 | Access kind not allowed by the segment type |
| rsp_np_fault | output | 1 | Descriptor not present |

## Verification
The assertions assume that `rst` is held with `req_valid` and `load_valid` low, and that segment indices stay below the configured count. The bench keeps to both: it drives every strobe on the falling edge and only ever uses indices 0 to 5. The address-tracking property also assumes that back-to-back requests to one register see no intervening reload of that register. The bench's same-cycle load test is arranged so that a reload never lands between two consecutive requests to the same entry.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int DESC_W     = 64;
  localparam int OFF_W      = 32;
  localparam int LIM_RAW_W  = 20;
  localparam int PAGE_SHIFT = 12;

  typedef enum logic [1:0] {
    KIND_RD  = 2'd0,
    KIND_WR  = 2'd1,
    KIND_EX  = 2'd2,
    KIND_EX2 = 2'd3
  } acc_kind_e;

  typedef struct packed {
    logic [OFF_W-1:0] base;
    logic [OFF_W-1:0] lim;     // effective (scaled) limit
    logic             code;    // type bit 43
    logic             tmid;    // type bit 42: expand-down / conforming
    logic             tlow;    // type bit 41: writable / readable
    logic             nonsys;  // bit 44
    logic             present; // bit 47
    logic             big;     // bit 54
  } seg_ent_t;
endpackage

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
  import seg_pkg::*;
#(
  parameter int NSEG  = 6,
  parameter int SEL_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [DESC_W-1:0] ld_desc,
  input  logic [SEL_W-1:0]  rd_sel,
  output seg_ent_t          rd_ent
);
  localparam int PAD_W = OFF_W - LIM_RAW_W;

  seg_ent_t               ent [NSEG];
  seg_ent_t               new_ent;
  logic [LIM_RAW_W-1:0]   raw_lim;
  logic                   unused_desc_bits;

  assign unused_desc_bits = ^{ld_desc[40], ld_desc[46:45], ld_desc[53:52]};
  assign raw_lim = {ld_desc[51:48], ld_desc[15:0]};

  always_comb begin
    new_ent.base    = {ld_desc[63:56], ld_desc[39:16]};
    new_ent.lim     = ld_desc[55] ? {raw_lim, {PAGE_SHIFT{1'b1}}}
                                  : {{PAD_W{1'b0}}, raw_lim};
    new_ent.code    = ld_desc[43];
    new_ent.tmid    = ld_desc[42];
    new_ent.tlow    = ld_desc[41];
    new_ent.nonsys  = ld_desc[44];
    new_ent.present = ld_desc[47];
    new_ent.big     = ld_desc[54];
  end

  for (genvar g = 0; g < NSEG; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (rst)
        ent[g] <= '0;
      else if (ld_valid && ld_sel == SEL_W'(g))
        ent[g] <= new_ent;
    end
  end

  always_comb begin
    rd_ent = '0;
    for (int i = 0; i < NSEG; i++)
      if (rd_sel == SEL_W'(i)) rd_ent = ent[i];
  end
endmodule

// File: rtl/seg_limit_eval.sv
module seg_limit_eval
  import seg_pkg::*;
(
  input  seg_ent_t         ent,
  input  logic [OFF_W-1:0] offset,
  input  logic [1:0]       size_code,
  output logic             lim_fault
);
  logic [OFF_W:0] span_m1;
  logic [OFF_W:0] last_byte;
  logic [OFF_W:0] upper;
  logic           exp_down;

  always_comb begin
    case (size_code)
      2'd0:    span_m1 = '0;
      2'd1:    span_m1 = (OFF_W+1)'(1);
      default: span_m1 = (OFF_W+1)'(3);
    endcase
    last_byte = {1'b0, offset} + span_m1;
    exp_down  = !ent.code && ent.tmid;
    upper     = ent.big ? {1'b0, {OFF_W{1'b1}}} : (OFF_W+1)'(17'h0FFFF);
    if (exp_down)
      lim_fault = (offset <= ent.lim) || (last_byte > upper);
    else
      lim_fault = last_byte > {1'b0, ent.lim};
  end
endmodule

// File: rtl/seg_type_eval.sv
module seg_type_eval
  import seg_pkg::*;
(
  input  seg_ent_t   ent,
  input  logic [1:0] kind,
  output logic       type_fault
);
  acc_kind_e k;
  assign k = acc_kind_e'(kind);

  always_comb begin
    if (!ent.nonsys)
      type_fault = 1'b1;
    else if (ent.code) begin
      case (k)
        KIND_WR: type_fault = 1'b1;
        KIND_RD: type_fault = !ent.tlow;
        default: type_fault = 1'b0;
      endcase
    end else begin
      case (k)
        KIND_WR: type_fault = !ent.tlow;
        KIND_RD: type_fault = 1'b0;
        default: type_fault = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/seg_check_top.sv
module seg_check_top
  import seg_pkg::*;
#(
  parameter int NSEG  = 6,
  parameter int SEL_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_valid,
  input  logic [SEL_W-1:0]  load_seg,
  input  logic [63:0]       load_desc,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_seg,
  input  logic [31:0]       req_offset,
  input  logic [1:0]        req_size,
  input  logic [1:0]        req_kind,
  output logic              rsp_valid,
  output logic [31:0]       rsp_lin_addr,
  output logic              rsp_limit_fault,
  output logic              rsp_type_fault,
  output logic              rsp_np_fault
);
  seg_ent_t cur;
  logic     lim_f;
  logic     typ_f;

  seg_desc_cache #(.NSEG(NSEG), .SEL_W(SEL_W)) u_cache (
    .clk(clk), .rst(rst),
    .ld_valid(load_valid), .ld_sel(load_seg), .ld_desc(load_desc),
    .rd_sel(req_seg), .rd_ent(cur)
  );

  seg_limit_eval u_lim (
    .ent(cur), .offset(req_offset), .size_code(req_size), .lim_fault(lim_f)
  );

  seg_type_eval u_typ (
    .ent(cur), .kind(req_kind), .type_fault(typ_f)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid       <= 1'b0;
      rsp_lin_addr    <= '0;
      rsp_limit_fault <= 1'b0;
      rsp_type_fault  <= 1'b0;
      rsp_np_fault    <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_lin_addr    <= cur.base + req_offset;
        rsp_np_fault    <= !cur.present;
        rsp_limit_fault <= cur.present && lim_f;
        rsp_type_fault  <= cur.present && typ_f;
      end
    end
  end
endmodule

// File: rtl/seg_check_sva.sv
module seg_check_sva #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             load_valid,
  input logic [SEL_W-1:0] load_seg,
  input logic             req_valid,
  input logic [SEL_W-1:0] req_seg,
  input logic [31:0]      req_offset,
  input logic             rsp_valid,
  input logic [31:0]      rsp_lin_addr,
  input logic             rsp_limit_fault,
  input logic             rsp_type_fault,
  input logic             rsp_np_fault
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2

  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(rsp_lin_addr) && $stable(rsp_np_fault)
                    && $stable(rsp_limit_fault) && $stable(rsp_type_fault))); // R2

  AST_NP_ALONE: assert property (@(posedge clk) disable iff (rst)
    rsp_np_fault |-> (!rsp_limit_fault && !rsp_type_fault)); // R8

  AST_ADDR_TRACKS_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $past(req_valid) && !$past(rst) && req_seg == $past(req_seg)
     && !($past(load_valid) && $past(load_seg) == req_seg))
    |=> ((rsp_lin_addr - $past(rsp_lin_addr))
         == ($past(req_offset) - $past(req_offset, 2)))); // R1
endmodule

bind seg_check_top seg_check_sva #(.SEL_W(SEL_W)) u_sva (
  .clk(clk), .rst(rst), .load_valid(load_valid), .load_seg(load_seg),
  .req_valid(req_valid), .req_seg(req_seg), .req_offset(req_offset),
  .rsp_valid(rsp_valid), .rsp_lin_addr(rsp_lin_addr),
  .rsp_limit_fault(rsp_limit_fault), .rsp_type_fault(rsp_type_fault),
  .rsp_np_fault(rsp_np_fault)
);

// File: tb/seg_check_top_test.sv
`timescale 1ns/1ps
module seg_check_top_test;
  localparam int NSEG = 6;
  localparam int SW   = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_valid = 1'b0;
  logic [SW-1:0] load_seg = '0;
  logic [63:0] load_desc = '0;
  logic        req_valid = 1'b0;
  logic [SW-1:0] req_seg = '0;
  logic [31:0] req_offset = '0;
  logic [1:0]  req_size = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic [31:0] rsp_lin_addr;
  logic        rsp_limit_fault, rsp_type_fault, rsp_np_fault;

  int checks = 0;
  int fails  = 0;

  seg_check_top #(.NSEG(NSEG)) uut (
    .clk(clk), .rst(rst), .load_valid(load_valid), .load_seg(load_seg),
    .load_desc(load_desc), .req_valid(req_valid), .req_seg(req_seg),
    .req_offset(req_offset), .req_size(req_size), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_lin_addr(rsp_lin_addr),
    .rsp_limit_fault(rsp_limit_fault), .rsp_type_fault(rsp_type_fault),
    .rsp_np_fault(rsp_np_fault)
  );

  always #2 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic logic [63:0] mk_desc(input logic [31:0] base, input logic [19:0] lim,
      input logic [2:0] typ, input logic s, input logic p, input logic d, input logic g);
    logic [63:0] r;
    r = '0;
    r[15:0]  = lim[15:0];
    r[39:16] = base[23:0];
    r[43:41] = typ;
    r[44]    = s;
    r[47]    = p;
    r[51:48] = lim[19:16];
    r[54]    = d;
    r[55]    = g;
    r[63:56] = base[31:24];
    return r;
  endfunction

  // expected {np, limit, type} from the requirement text
  function automatic logic [2:0] exp_flags(input logic [63:0] ds, input logic [31:0] off,
      input logic [1:0] sz, input logic [1:0] kd);
    logic [63:0] raw, lim, last, upper, nb;
    logic [2:0] t;
    logic lf, tf, ed;
    if (!ds[47]) return 3'b100;
    raw = {44'd0, ds[51:48], ds[15:0]};
    lim = ds[55] ? raw * 64'd4096 + 64'd4095 : raw;
    nb  = (sz == 2'd0) ? 64'd1 : (sz == 2'd1) ? 64'd2 : 64'd4;
    last = {32'd0, off} + nb - 64'd1;
    t = ds[43:41];
    ed = (t[2] == 1'b0) && (t[1] == 1'b1);
    upper = ds[54] ? 64'hFFFF_FFFF : 64'hFFFF;
    if (ed) lf = ({32'd0, off} <= lim) || (last > upper);
    else    lf = last > lim;
    if (!ds[44]) tf = 1'b1;
    else if (t[2]) tf = (kd == 2'd1) || (kd == 2'd0 && !t[0]);
    else           tf = (kd == 2'd1 && !t[0]) || (kd >= 2'd2);
    return {1'b0, lf, tf};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic do_load(input logic [SW-1:0] sg, input logic [63:0] ds);
    @(negedge clk);
    load_valid = 1'b1; load_seg = sg; load_desc = ds;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic do_req(input logic [SW-1:0] sg, input logic [31:0] off,
                        input logic [1:0] sz, input logic [1:0] kd);
    @(negedge clk);
    req_valid = 1'b1; req_seg = sg; req_offset = off; req_size = sz; req_kind = kd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic req_and_check(input logic [SW-1:0] sg, input logic [63:0] ds,
      input logic [31:0] off, input logic [1:0] sz, input logic [1:0] kd, input string tag);
    logic [2:0] e;
    logic [31:0] ea;
    do_req(sg, off, sz, kd);
    e  = exp_flags(ds, off, sz, kd);
    ea = {ds[63:56], ds[39:16]} + off;
    chk(rsp_valid == 1'b1, "R2", "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(rsp_lin_addr == ea, "R1", "linear address", 64'(rsp_lin_addr), 64'(ea));
    chk({rsp_np_fault, rsp_limit_fault, rsp_type_fault} == e, tag, "flags {np,lim,type}",
        64'({rsp_np_fault, rsp_limit_fault, rsp_type_fault}), 64'(e));
  endtask

  logic [63:0] dtab [10];
  string       ttab [10];
  logic [31:0] elim [10];

  initial begin
    logic [63:0] da, db, dc;
    dtab[0] = mk_desc(32'h0000_1000, 20'h001F4, 3'b001, 1, 1, 0, 0); ttab[0] = "R3";
    dtab[1] = mk_desc(32'h0010_0000, 20'h00003, 3'b000, 1, 1, 0, 1); ttab[1] = "R4";
    dtab[2] = mk_desc(32'h0002_0000, 20'h00FF0, 3'b011, 1, 1, 0, 0); ttab[2] = "R5";
    dtab[3] = mk_desc(32'h0300_0000, 20'hFFFF0, 3'b010, 1, 1, 1, 1); ttab[3] = "R5";
    dtab[4] = mk_desc(32'h0000_8000, 20'h00100, 3'b100, 1, 1, 0, 0); ttab[4] = "R6";
    dtab[5] = mk_desc(32'hFFFF_F000, 20'hFFFFF, 3'b101, 1, 1, 1, 1); ttab[5] = "R6";
    dtab[6] = mk_desc(32'h0000_4000, 20'h00200, 3'b110, 1, 1, 0, 0); ttab[6] = "R6";
    dtab[7] = mk_desc(32'h0000_6000, 20'h00200, 3'b111, 1, 1, 0, 0); ttab[7] = "R6";
    dtab[8] = mk_desc(32'h0000_9000, 20'h00300, 3'b001, 0, 1, 0, 0); ttab[8] = "R7";
    dtab[9] = mk_desc(32'h0000_A000, 20'h00300, 3'b001, 1, 0, 0, 0); ttab[9] = "R8";
    for (int i = 0; i < 10; i++)
      elim[i] = dtab[i][55] ? {dtab[i][51:48], dtab[i][15:0], 12'hFFF}
                            : {12'd0, dtab[i][51:48], dtab[i][15:0]};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk(rsp_valid == 1'b0 && rsp_lin_addr == 32'd0 && !rsp_np_fault
        && !rsp_limit_fault && !rsp_type_fault, "R10", "reset outputs",
        64'({rsp_valid, rsp_np_fault, rsp_limit_fault, rsp_type_fault}), 64'd0);
    do_req(3'd2, 32'h10, 2'd0, 2'd0);
    chk(rsp_np_fault == 1'b1 && !rsp_limit_fault && !rsp_type_fault, "R10",
        "np before any load", 64'({rsp_np_fault, rsp_limit_fault, rsp_type_fault}), 64'h4);

    // R3: the worked boundary case
    do_load(3'd0, dtab[0]);
    req_and_check(3'd0, dtab[0], 32'd498, 2'd1, 2'd0, "R3");
    chk(rsp_limit_fault == 1'b0, "R3", "2-byte at 498 in limit 500", 64'(rsp_limit_fault), 64'd0);
    req_and_check(3'd0, dtab[0], 32'd498, 2'd2, 2'd0, "R3");
    chk(rsp_limit_fault == 1'b1, "R3", "4-byte at 498 in limit 500", 64'(rsp_limit_fault), 64'd1);

    // R2: outputs hold while idle
    @(negedge clk);
    chk(rsp_valid == 1'b0 && rsp_limit_fault == 1'b1, "R2", "hold after strobe",
        64'({rsp_valid, rsp_limit_fault}), 64'd1);

    // near-exhaustive sweep
    for (int i = 0; i < 10; i++) begin
      logic [SW-1:0] sg;
      logic [31:0] offs [14];
      sg = SW'(i % NSEG);
      do_load(sg, dtab[i]);
      for (int k = 0; k < 7; k++) offs[k] = elim[i] - 32'd4 + 32'(k);
      offs[7]  = 32'd0;          offs[8]  = 32'h0000_FFFD;
      offs[9]  = 32'h0000_FFFE;  offs[10] = 32'h0000_FFFF;
      offs[11] = 32'h0001_0000;  offs[12] = 32'hFFFF_FFFD;
      offs[13] = 32'hFFFF_FFFF;
      for (int o = 0; o < 14; o++)
        for (int s = 0; s < 3; s++)
          for (int k = 0; k < 3; k++)
            req_and_check(sg, dtab[i], offs[o], 2'(s), 2'(k), ttab[i]);
    end

    // R9: hidden descriptor cache
    da = mk_desc(32'h0000_2000, 20'h0FFFF, 3'b001, 1, 1, 0, 0);
    db = mk_desc(32'h0005_0000, 20'h0FFFF, 3'b001, 1, 1, 0, 0);
    dc = mk_desc(32'h0700_0000, 20'h0FFFF, 3'b001, 1, 1, 0, 0);
    do_load(3'd3, da);
    do_load(3'd4, dc);
    @(negedge clk);
    load_desc = db;                       // bus changes, no load strobe
    do_req(3'd3, 32'h10, 2'd0, 2'd0);
    chk(rsp_lin_addr == 32'h2010, "R9", "bus change without load", 64'(rsp_lin_addr), 64'h2010);
    @(negedge clk);
    load_valid = 1'b1; load_seg = 3'd3; load_desc = db;
    req_valid = 1'b1; req_seg = 3'd3; req_offset = 32'h20; req_size = 2'd0; req_kind = 2'd0;
    @(negedge clk);
    load_valid = 1'b0; req_valid = 1'b0;
    chk(rsp_lin_addr == 32'h2020, "R9", "same-cycle load uses old base", 64'(rsp_lin_addr), 64'h2020);
    do_req(3'd3, 32'h20, 2'd0, 2'd0);
    chk(rsp_lin_addr == 32'h0005_0020, "R9", "reload takes effect", 64'(rsp_lin_addr), 64'h50020);
    do_req(3'd4, 32'h30, 2'd0, 2'd0);
    chk(rsp_lin_addr == 32'h0700_0030, "R9", "other entry untouched", 64'(rsp_lin_addr), 64'h7000030);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule